// File: doc/BRIEF.md
# Memory-Saturation-Aware Warp Scheduler

This block is the issue scheduler for one streaming multiprocessor. Every cycle it looks at a fixed pool of warps and names at most one of them for issue. For each warp it sees three bits: an instruction is waiting, that instruction is a memory operation, and that instruction depends on a load the warp has not yet received. Decode, the register file and the data cache sit outside the block.

Two near-full flags come from the memory side, one from the miss-status register pool and one from the miss queue. While both are low, the scheduler treats every warp alike and uses a greedy-then-oldest pick. If either flag is high, it moves into a memory-priority mode. In that mode a single owner warp holds the only right to send memory instructions past L1, and every other warp may issue only compute work. The owner therefore drains its memory requests in one burst and can start computing early. When the owner stalls on one of its own loads, ownership moves on to the next warp that is waiting with a memory instruction.

Top module: `mem_sat_sched`

## Requirements
- R1: Saturation is the OR of `mshr_near_full` and `missq_near_full`. A cycle with saturation high puts the scheduler in memory-priority mode from the next cycle on, whichever flag caused it.
- R2: The first cycle after saturation is sampled low, the scheduler is back in equal-priority mode and has no owner. All ready warps may then issue memory instructions again.
- R3: Greedy rule. The warp that issued most recently is issued again for as long as it stays eligible.
- R4: When the greedy rule does not apply, the lowest-numbered eligible warp is issued.
- R5: A warp is ready when `inst_valid` is 1 and `dep_pending` is 0. If no warp is eligible, `issue_valid` is 0.
- R6: Owner search starts just after the previous owner index and wraps around. It takes the first warp that is ready with `inst_is_mem`=1 (1 means memory, 0 means compute). After reset the previous owner index is NUM_WARPS-1, so the first search starts at warp 0. Any saturated cycle with no owner repeats the search.
- R7: In memory-priority mode, a warp that is not the owner and has a memory instruction is not eligible. Ready compute warps stay eligible.
- R8: In memory-priority mode, an eligible owner is issued ahead of every other warp, including the greedy warp.
- R9: A saturated cycle in which the owner has `dep_pending`=1 hands ownership, on the next cycle, to the warp found by the R6 search. If the search finds no warp, the owner stays the same.
- R10: At most one warp issues per cycle. `issue_warp` is the binary index of that warp and is meaningful only while `issue_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | NUM_WARPS | Per warp: an instruction is waiting |
| inst_is_mem | input | NUM_WARPS | Per warp: 1 = memory instruction, 0 = compute |
| dep_pending | input | NUM_WARPS | Per warp: the instruction waits on an outstanding load |
| mshr_near_full | input | 1 | Miss-status register pool almost full |
| missq_near_full | input | 1 | Miss queue almost full |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Index of the issued warp |

## Verification
The hardest situation to reach is an owner handover that actually finds a successor. It needs saturation held for several cycles, an owner that has just become blocked on its own load, and at least one other warp waiting with a memory instruction, all in the same cycle. A directed sequence builds this step by step: it raises saturation, lets warp 3 take ownership, then blocks warp 3 while warp 5 waits with a memory instruction and warp 6 waits with compute. Long random runs follow. In these, saturation is held in stretches and dependence is sparse, so handovers with and without a successor both happen many times, and a cycle-accurate model checks each one.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int DEFAULT_WARPS = 8;

    typedef enum logic {
        MODE_EQUAL  = 1'b0,
        MODE_MEMPRI = 1'b1
    } sched_mode_e;

    typedef struct packed {
        logic ready;
        logic is_mem;
    } warp_req_t;

    function automatic logic saturated(input logic mshr_flag, input logic missq_flag);
        return mshr_flag | missq_flag;
    endfunction

endpackage

// File: rtl/warp_ready_check.sv
module warp_ready_check
    import sched_pkg::*;
#(
    parameter int NW = DEFAULT_WARPS,
    localparam int WW = $clog2(NW)
) (
    input  logic [NW-1:0] inst_valid,
    input  logic [NW-1:0] inst_is_mem,
    input  logic [NW-1:0] dep_pending,
    input  sched_mode_e   mode,
    input  logic [WW-1:0] owner,
    input  logic          owner_vld,
    output logic [NW-1:0] mem_ready,
    output logic [NW-1:0] eligible
);

    warp_req_t req [NW];

    for (genvar g = 0; g < NW; g++) begin : g_warp
        logic is_owner;
        assign req[g].ready  = inst_valid[g] & ~dep_pending[g];
        assign req[g].is_mem = inst_is_mem[g];
        assign is_owner      = owner_vld && (owner == WW'(g));
        assign mem_ready[g]  = req[g].ready & req[g].is_mem;
        always_comb begin
            if (mode == MODE_MEMPRI)
                eligible[g] = req[g].ready & (~req[g].is_mem | is_owner);
            else
                eligible[g] = req[g].ready;
        end
    end

endmodule

// File: rtl/owner_ctrl.sv
module owner_ctrl
    import sched_pkg::*;
#(
    parameter int NW = DEFAULT_WARPS,
    localparam int WW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mshr_near_full,
    input  logic          missq_near_full,
    input  logic [NW-1:0] mem_ready,
    input  logic [NW-1:0] dep_pending,
    output sched_mode_e   mode,
    output logic [WW-1:0] owner,
    output logic          owner_vld
);

    sched_mode_e   mode_q;
    logic [WW-1:0] owner_q;
    logic          owner_vld_q;
    logic          sat;
    logic          want_new;
    logic          found;
    logic [WW-1:0] cand;

    assign sat = saturated(mshr_near_full, missq_near_full);

    // Rotating search that starts one place after the current owner.
    always_comb begin
        found = 1'b0;
        cand  = owner_q;
        for (int k = 1; k <= NW; k++) begin
            int idx;
            idx = (int'(owner_q) + k) % NW;
            if (!found && mem_ready[idx]) begin
                found = 1'b1;
                cand  = WW'(idx);
            end
        end
    end

    assign want_new = (mode_q == MODE_EQUAL) || !owner_vld_q || dep_pending[owner_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_EQUAL;
            owner_q     <= WW'(NW - 1);
            owner_vld_q <= 1'b0;
        end else if (!sat) begin
            mode_q      <= MODE_EQUAL;
            owner_vld_q <= 1'b0;
        end else begin
            mode_q <= MODE_MEMPRI;
            if (want_new && found) begin
                owner_q     <= cand;
                owner_vld_q <= 1'b1;
            end
        end
    end

    assign mode      = mode_q;
    assign owner     = owner_q;
    assign owner_vld = owner_vld_q;

endmodule

// File: rtl/issue_select.sv
module issue_select
    import sched_pkg::*;
#(
    parameter int NW = DEFAULT_WARPS,
    localparam int WW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] eligible,
    input  sched_mode_e   mode,
    input  logic [WW-1:0] owner,
    input  logic          owner_vld,
    output logic          issue_valid,
    output logic [WW-1:0] issue_warp
);

    logic [WW-1:0] last_q;
    logic          last_vld_q;
    logic          any_elig;
    logic [WW-1:0] lowest;

    always_comb begin
        lowest = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (eligible[i]) lowest = WW'(i);
        end
    end

    assign any_elig = |eligible;

    always_comb begin
        issue_valid = any_elig;
        if (mode == MODE_MEMPRI && owner_vld && eligible[owner])
            issue_warp = owner;
        else if (last_vld_q && eligible[last_q])
            issue_warp = last_q;
        else
            issue_warp = lowest;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q     <= '0;
            last_vld_q <= 1'b0;
        end else if (issue_valid) begin
            last_q     <= issue_warp;
            last_vld_q <= 1'b1;
        end
    end

endmodule

// File: rtl/mem_sat_sched.sv
module mem_sat_sched
    import sched_pkg::*;
#(
    parameter int NUM_WARPS = DEFAULT_WARPS,
    localparam int WW = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] inst_valid,
    input  logic [NUM_WARPS-1:0] inst_is_mem,
    input  logic [NUM_WARPS-1:0] dep_pending,
    input  logic                 mshr_near_full,
    input  logic                 missq_near_full,
    output logic                 issue_valid,
    output logic [WW-1:0]        issue_warp
);

    sched_mode_e          mode_q;
    logic [WW-1:0]        owner_q;
    logic                 owner_vld;
    logic [NUM_WARPS-1:0] mem_ready;
    logic [NUM_WARPS-1:0] eligible;

    warp_ready_check #(.NW(NUM_WARPS)) u_ready (
        .inst_valid  (inst_valid),
        .inst_is_mem (inst_is_mem),
        .dep_pending (dep_pending),
        .mode        (mode_q),
        .owner       (owner_q),
        .owner_vld   (owner_vld),
        .mem_ready   (mem_ready),
        .eligible    (eligible)
    );

    owner_ctrl #(.NW(NUM_WARPS)) u_owner (
        .clk             (clk),
        .rst             (rst),
        .mshr_near_full  (mshr_near_full),
        .missq_near_full (missq_near_full),
        .mem_ready       (mem_ready),
        .dep_pending     (dep_pending),
        .mode            (mode_q),
        .owner           (owner_q),
        .owner_vld       (owner_vld)
    );

    issue_select #(.NW(NUM_WARPS)) u_select (
        .clk         (clk),
        .rst         (rst),
        .eligible    (eligible),
        .mode        (mode_q),
        .owner       (owner_q),
        .owner_vld   (owner_vld),
        .issue_valid (issue_valid),
        .issue_warp  (issue_warp)
    );

endmodule

// File: rtl/mem_sat_sched_chk.sv
module mem_sat_sched_chk
    import sched_pkg::*;
#(
    parameter int NW = DEFAULT_WARPS,
    localparam int WW = $clog2(NW)
) (
    input logic          clk,
    input logic          rst,
    input logic [NW-1:0] inst_valid,
    input logic [NW-1:0] inst_is_mem,
    input logic [NW-1:0] dep_pending,
    input logic          mshr_near_full,
    input logic          missq_near_full,
    input logic          issue_valid,
    input logic [WW-1:0] issue_warp,
    input sched_mode_e   mode_q,
    input logic [WW-1:0] owner_q,
    input logic          owner_vld
);

    // R5
    issue_ready_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (inst_valid[issue_warp] && !dep_pending[issue_warp]));

    // R5
    idle_when_none_chk: assert property (@(posedge clk) disable iff (rst)
        ((inst_valid & ~dep_pending) == '0) |-> !issue_valid);

    // R1
    enter_mempri_chk: assert property (@(posedge clk) disable iff (rst)
        (mshr_near_full || missq_near_full) |=> (mode_q == MODE_MEMPRI));

    // R2
    leave_mempri_chk: assert property (@(posedge clk) disable iff (rst)
        (!mshr_near_full && !missq_near_full) |=> (mode_q == MODE_EQUAL && !owner_vld));

    // R7
    mem_only_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_MEMPRI && issue_valid && inst_is_mem[issue_warp])
            |-> (owner_vld && issue_warp == owner_q));

    // R9
    owner_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_MEMPRI && owner_vld && !dep_pending[owner_q]
            && (mshr_near_full || missq_near_full))
            |=> (owner_vld && owner_q == $past(owner_q)));

endmodule

bind mem_sat_sched mem_sat_sched_chk #(.NW(NUM_WARPS)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .inst_valid      (inst_valid),
    .inst_is_mem     (inst_is_mem),
    .dep_pending     (dep_pending),
    .mshr_near_full  (mshr_near_full),
    .missq_near_full (missq_near_full),
    .issue_valid     (issue_valid),
    .issue_warp      (issue_warp),
    .mode_q          (mode_q),
    .owner_q         (owner_q),
    .owner_vld       (owner_vld)
);

// File: tb/tb_mem_sat_sched.sv
module tb_mem_sat_sched;

    localparam int NW = 8;
    localparam int WW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NW-1:0] inst_valid = '0;
    logic [NW-1:0] inst_is_mem = '0;
    logic [NW-1:0] dep_pending = '0;
    logic          mshr_near_full = 1'b0;
    logic          missq_near_full = 1'b0;
    logic          issue_valid;
    logic [WW-1:0] issue_warp;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    int m_mp = 0, m_own = NW - 1, m_own_v = 0, m_last = 0, m_last_v = 0;

    always #4 clk = ~clk;

    mem_sat_sched #(.NUM_WARPS(NW)) dut (
        .clk(clk), .rst(rst),
        .inst_valid(inst_valid), .inst_is_mem(inst_is_mem), .dep_pending(dep_pending),
        .mshr_near_full(mshr_near_full), .missq_near_full(missq_near_full),
        .issue_valid(issue_valid), .issue_warp(issue_warp)
    );

    task automatic step(input logic [NW-1:0] v, input logic [NW-1:0] m,
                        input logic [NW-1:0] d, input logic sa, input logic sb,
                        input string tag);
        int  elig [NW];
        int  exp_v, exp_w, sat, found, cand;
        @(negedge clk);
        inst_valid = v; inst_is_mem = m; dep_pending = d;
        mshr_near_full = sa; missq_near_full = sb;
        #1;
        for (int i = 0; i < NW; i++) begin
            int rdy;
            rdy = (v[i] && !d[i]) ? 1 : 0;
            elig[i] = rdy;
            if (m_mp != 0 && m[i] && !(m_own_v != 0 && m_own == i)) elig[i] = 0;
        end
        exp_v = 0; exp_w = 0;
        if (m_mp != 0 && m_own_v != 0 && elig[m_own] != 0) begin
            exp_v = 1; exp_w = m_own;
        end else if (m_last_v != 0 && elig[m_last] != 0) begin
            exp_v = 1; exp_w = m_last;
        end else begin
            for (int i = NW - 1; i >= 0; i--)
                if (elig[i] != 0) begin exp_v = 1; exp_w = i; end
        end
        n_chk++;
        if (issue_valid !== exp_v[0] || (exp_v != 0 && int'(issue_warp) != exp_w)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b warp=%0d, expected valid=%0d warp=%0d",
                     tag, issue_valid, issue_warp, exp_v, exp_w);
        end
        // advance model
        sat = (sa || sb) ? 1 : 0;
        found = 0; cand = m_own;
        for (int k = 1; k <= NW; k++) begin
            int idx;
            idx = (m_own + k) % NW;
            if (found == 0 && v[idx] && !d[idx] && m[idx]) begin found = 1; cand = idx; end
        end
        if (exp_v != 0) begin m_last = exp_w; m_last_v = 1; end
        if (sat == 0) begin
            m_mp = 0; m_own_v = 0;
        end else begin
            if ((m_mp == 0 || m_own_v == 0 || d[m_own]) && found != 0) begin
                m_own = cand; m_own_v = 1;
            end
            m_mp = 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R5 reset state: nothing waiting, nothing issues
        step(8'h00, 8'h00, 8'h00, 0, 0, "R5_reset");
        // R4 lowest ready
        step(8'h24, 8'h00, 8'h00, 0, 0, "R4_lowest");
        // R3 greedy stays on warp 2 although warp 1 is ready
        step(8'h26, 8'h00, 8'h00, 0, 0, "R3_greedy");
        // R5 dependence blocks warp 2, R4 picks 1
        step(8'h26, 8'h00, 8'h04, 0, 0, "R5_dep");
        step(8'hFF, 8'h00, 8'hFF, 0, 0, "R5_none");
        // R1 via miss queue flag only: mem warps 3 and 5, compute warp 0
        step(8'h29, 8'h28, 8'h00, 0, 1, "R1_enter");
        // R6 owner 3 chosen; R8 owner beats greedy/lowest warp 0
        step(8'h29, 8'h28, 8'h00, 0, 1, "R8_owner_first");
        // R7 owner 3 blocked, warp 5 memory not allowed, compute warp 6 issues
        step(8'h68, 8'h28, 8'h08, 1, 0, "R7_non_owner_mem");
        // R9 handover to warp 5, which now beats greedy warp 6
        step(8'h60, 8'h20, 8'h00, 1, 0, "R9_handover");
        // R9 no successor: owner 5 blocked, only compute warp 6
        step(8'h60, 8'h20, 8'h20, 1, 1, "R9_none");
        step(8'h22, 8'h22, 8'h00, 1, 0, "R9_kept_owner");
        // R2 saturation clears: still memory-priority this cycle, then equal
        step(8'h02, 8'h02, 8'h00, 0, 0, "R2_last_mp");
        step(8'h02, 8'h02, 8'h00, 0, 0, "R2_equal");
        // R6 fresh entry searches after previous owner 5: warp 1 (wraps)
        step(8'h03, 8'h02, 8'h00, 1, 0, "R6_enter");
        step(8'h83, 8'h82, 8'h00, 1, 0, "R6_wrap_owner");
        // random phase
        begin
            logic sa = 0, sb = 0;
            for (int n = 0; n < 6000; n++) begin
                logic [NW-1:0] v, mm, dd;
                if ($urandom_range(0, 15) == 0) sa = ~sa;
                if ($urandom_range(0, 23) == 0) sb = ~sb;
                v  = NW'($urandom) | NW'($urandom);
                mm = NW'($urandom);
                dd = NW'($urandom) & NW'($urandom);
                step(v, mm, dd, sa, sb, "R10_random");
            end
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule